// File: doc/BRIEF.md
# Power-On and Watchdog Reset Generator

This block is a digital supervisor that owns a board-level, active-low reset line. It holds reset asserted after power-up. It asserts reset whenever an external comparator reports that the supply is not good. It also asserts reset when software fails to strobe a watchdog within a selected interval. Every reset cause is followed by a full hold period, so the processor always sees a reset pulse of at least the minimum length.

All timing runs on a prescaled tick: the system clock is divided by `TICK_DIV`, and the hold time and the three watchdog intervals are counted in ticks. A 2-bit select comes from a persistent configuration register outside the block. It picks one of the three intervals or turns the watchdog off; the factory value of that register is `11`. The output is modelled as an open-drain pin: a pull-down enable, and the level the line shows with its external pull-up.

The power-up reset is the asynchronous `por_n_i` input. The prescaler is restarted by any reset cause and by an accepted kick, so hold and timeout lengths are exact cycle counts.

Top module: `rstgen_supervisor`

## Requirements
- R1: After `por_n_i` rises, `rst_n_o` stays 0 for exactly `HOLD_TICKS*TICK_DIV` rising clock edges and reads 1 after the edge that completes that count.
- R2: A 0 on `supply_ok_i` sampled at a clock edge makes `rst_n_o` 0 after that edge, and it stays 0 while the input stays 0.
- R3: After the last edge that samples `supply_ok_i` at 0, `rst_n_o` returns to 1 exactly `HOLD_TICKS*TICK_DIV` edges later.
- R4: With the watchdog enabled and no accepted kick, `rst_n_o` goes to 0 exactly `limit*TICK_DIV + 1` edges after reset release or after the last accepted kick.
- R5: Select encoding: `wd_sel_i` = 01 sets the limit to `WD_SHORT_TICKS`, 10 to `WD_MID_TICKS`, and 11 (the factory value) to `WD_LONG_TICKS`.
- R6: `wd_sel_i` = 00 disables the watchdog: with the supply good, `rst_n_o` never falls after release.
- R7: A 1 on `wd_kick_i` sampled while reset is released restarts the full watchdog interval from that edge.
- R8: Kicks sampled while reset is asserted are ignored: release timing is unchanged, and the watchdog starts from zero at release.
- R9: A watchdog-caused reset lasts exactly `HOLD_TICKS*TICK_DIV` edges after the edge that asserted it.
- R10: Open-drain model: `rst_pull_en_o` is 1 exactly when `rst_n_o` is 0, including during `por_n_i` low.
- R11: A new cause during a hold period restarts the full hold from the new cause's last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Asynchronous power-up reset, active low |
| supply_ok_i | input | 1 | Supply-good flag from the external comparator, 1 = good |
| wd_kick_i | input | 1 | Watchdog restart strobe, one cycle |
| wd_sel_i | input | 2 | Watchdog interval select from the persistent register |
| rst_pull_en_o | output | 1 | Pull-down enable of the open-drain reset pin |
| rst_n_o | output | 1 | Level of the reset line, active low |

## Verification
On every cycle, the assertions check four things: a supply-low flag or an internal cause forces reset on the next edge, release happens only on a tick with no cause present, the watchdog never expires while reset is active or when it is turned off, and an accepted kick is never followed directly by an expiry. The bench scenarios are the only place where the cycle counts themselves are shown. These are the exact hold length after power-up, after a supply dip and after a watchdog expiry, the three interval codes, the restart of the hold by a second cause, and the fact that kicks during reset leave release timing and the fresh watchdog interval unchanged.

// File: rtl/rstgen_pkg.sv
`timescale 1ns/1ps
package rstgen_pkg;

  typedef enum logic [1:0] {
    WD_OFF   = 2'b00,
    WD_SHORT = 2'b01,
    WD_MID   = 2'b10,
    WD_LONG  = 2'b11
  } wd_sel_e;

  // Watchdog limit in ticks for a select code; 0 when disabled.
  function automatic int unsigned wd_limit_ticks(input logic [1:0] sel,
                                                 input int unsigned t_short,
                                                 input int unsigned t_mid,
                                                 input int unsigned t_long);
    case (sel)
      WD_SHORT: return t_short;
      WD_MID:   return t_mid;
      WD_LONG:  return t_long;
      default:  return 0;
    endcase
  endfunction

  function automatic logic wd_enabled(input logic [1:0] sel);
    return sel != WD_OFF;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Reset pulse length in clock cycles.
  function automatic int unsigned hold_cycles(input int unsigned ticks,
                                              input int unsigned div);
    return ticks * div;
  endfunction

endpackage

// File: rtl/rstgen_tick_gen.sv
`timescale 1ns/1ps
module rstgen_tick_gen #(
  parameter int unsigned TICK_DIV = 1000
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic clr_i,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_passthru
      assign tick_o = !clr_i;
    end else begin : g_count
      localparam int PCW = $clog2(TICK_DIV);
      localparam logic [PCW-1:0] LAST = PCW'(TICK_DIV - 1);

      logic [PCW-1:0] pcnt_q;
      logic           at_last;

      assign at_last = (pcnt_q == LAST);
      assign tick_o  = at_last && !clr_i;

      always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i)        pcnt_q <= '0;
        else if (clr_i)      pcnt_q <= '0;
        else if (at_last)    pcnt_q <= '0;
        else                 pcnt_q <= pcnt_q + 1'b1;
      end

      // Ticks are isolated single-cycle pulses (timing base for R1/R3)
      p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!por_n_i)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/rstgen_hold_ctrl.sv
`timescale 1ns/1ps
module rstgen_hold_ctrl #(
  parameter int unsigned HOLD_TICKS = 100
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic cause_i,
  input  logic tick_i,
  output logic rst_active_o
);

  localparam int HCW = $clog2(HOLD_TICKS + 1);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_TICKS - 1);

  logic [HCW-1:0] hcnt_q;
  logic           active_q;
  logic           hold_done;

  assign hold_done    = active_q && tick_i && (hcnt_q == HOLD_LAST);
  assign rst_active_o = active_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      active_q <= 1'b1;
      hcnt_q   <= '0;
    end else if (cause_i) begin
      active_q <= 1'b1;
      hcnt_q   <= '0;
    end else if (hold_done) begin
      active_q <= 1'b0;
      hcnt_q   <= '0;
    end else if (active_q && tick_i) begin
      hcnt_q   <= hcnt_q + 1'b1;
    end
  end

  // Any cause forces reset on the next edge
  p_cause_asserts_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    cause_i |=> rst_active_o);

  // Release only on a tick with no cause present
  p_release_on_tick_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(rst_active_o) |-> ($past(tick_i) && !$past(cause_i)));

endmodule

// File: rtl/rstgen_wdog.sv
`timescale 1ns/1ps
module rstgen_wdog
  import rstgen_pkg::*;
#(
  parameter int unsigned WD_SHORT_TICKS = 150,
  parameter int unsigned WD_MID_TICKS   = 600,
  parameter int unsigned WD_LONG_TICKS  = 1400
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic [1:0] sel_i,
  input  logic       kick_i,
  input  logic       tick_i,
  input  logic       rst_active_i,
  output logic       kick_accept_o,
  output logic       expire_o
);

  localparam int unsigned WD_MAX = max3(WD_SHORT_TICKS, WD_MID_TICKS, WD_LONG_TICKS);
  localparam int WCW = $clog2(WD_MAX + 1);

  logic [WCW-1:0] wcnt_q;
  logic [WCW-1:0] limit;
  logic           enabled;

  assign limit         = WCW'(wd_limit_ticks(sel_i, WD_SHORT_TICKS, WD_MID_TICKS, WD_LONG_TICKS));
  assign enabled       = wd_enabled(sel_i);
  assign kick_accept_o = kick_i && !rst_active_i;
  assign expire_o      = enabled && !rst_active_i && (wcnt_q >= limit);

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)                                     wcnt_q <= '0;
    else if (rst_active_i || kick_accept_o || !enabled) wcnt_q <= '0;
    else if (tick_i && (wcnt_q < limit))              wcnt_q <= wcnt_q + 1'b1;
  end

  // Disabled code never expires
  p_off_never_expires_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (sel_i == WD_OFF) |-> !expire_o);

  // No expiry while reset is held
  p_quiet_in_reset_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    rst_active_i |-> !expire_o);

  // An accepted kick restarts the interval
  p_kick_restarts_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (kick_accept_o && !expire_o) |=> !expire_o);

endmodule

// File: rtl/rstgen_supervisor.sv
`timescale 1ns/1ps
module rstgen_supervisor #(
  parameter int unsigned TICK_DIV       = 1000,
  parameter int unsigned HOLD_TICKS     = 100,
  parameter int unsigned WD_SHORT_TICKS = 150,
  parameter int unsigned WD_MID_TICKS   = 600,
  parameter int unsigned WD_LONG_TICKS  = 1400
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       supply_ok_i,
  input  logic       wd_kick_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_pull_en_o,
  output logic       rst_n_o
);

  logic tick;
  logic cause;
  logic expire;
  logic kick_accept;
  logic rst_active;
  logic prescale_clr;

  assign cause        = !supply_ok_i || expire;
  assign prescale_clr = cause || kick_accept;

  rstgen_tick_gen #(
    .TICK_DIV (TICK_DIV)
  ) tick_i0 (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .clr_i   (prescale_clr),
    .tick_o  (tick)
  );

  rstgen_hold_ctrl #(
    .HOLD_TICKS (HOLD_TICKS)
  ) hold_i0 (
    .clk_i        (clk_i),
    .por_n_i      (por_n_i),
    .cause_i      (cause),
    .tick_i       (tick),
    .rst_active_o (rst_active)
  );

  rstgen_wdog #(
    .WD_SHORT_TICKS (WD_SHORT_TICKS),
    .WD_MID_TICKS   (WD_MID_TICKS),
    .WD_LONG_TICKS  (WD_LONG_TICKS)
  ) wdog_i0 (
    .clk_i         (clk_i),
    .por_n_i       (por_n_i),
    .sel_i         (wd_sel_i),
    .kick_i        (wd_kick_i),
    .tick_i        (tick),
    .rst_active_i  (rst_active),
    .kick_accept_o (kick_accept),
    .expire_o      (expire)
  );

  assign rst_pull_en_o = rst_active;
  assign rst_n_o       = !rst_active;

  // Supply-low flag drives the pin low on the next edge
  p_supply_low_pin_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !supply_ok_i |=> !rst_n_o);

  // Watchdog expiry drives the pin low on the next edge
  p_expiry_pin_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    expire |=> rst_pull_en_o);

endmodule

// File: tb/rstgen_supervisor_tb.sv
`timescale 1ns/1ps
module rstgen_supervisor_tb_top;

  localparam int unsigned DIV  = 4;
  localparam int unsigned HOLD = 8;
  localparam int unsigned WS   = 5;
  localparam int unsigned WM   = 10;
  localparam int unsigned WL   = 16;
  localparam int unsigned HOLD_CYC = HOLD * DIV;

  logic       clk = 1'b0;
  logic       por_n;
  logic       supply_ok;
  logic       kick;
  logic [1:0] sel;
  logic       pull_en;
  logic       rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rstgen_supervisor #(
    .TICK_DIV       (DIV),
    .HOLD_TICKS     (HOLD),
    .WD_SHORT_TICKS (WS),
    .WD_MID_TICKS   (WM),
    .WD_LONG_TICKS  (WL)
  ) dut_i (
    .clk_i         (clk),
    .por_n_i       (por_n),
    .supply_ok_i   (supply_ok),
    .wd_kick_i     (kick),
    .wd_sel_i      (sel),
    .rst_pull_en_o (pull_en),
    .rst_n_o       (rst_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pin(input logic exp_n, input string tag);
    check(rst_n === exp_n, tag, int'(rst_n), int'(exp_n));
    check(pull_en === !exp_n, {tag, " R10 pull"}, int'(pull_en), int'(!exp_n));
  endtask

  // From the point right after the last cause edge: low for HOLD_CYC-1, high after HOLD_CYC
  task automatic check_release(input string tag);
    wait_n(HOLD_CYC - 1);
    check_pin(1'b0, {tag, " still held"});
    wait_n(1);
    check_pin(1'b1, {tag, " released"});
  endtask

  // From release or accepted kick: high after lim*DIV edges, low one edge later
  task automatic check_expiry(input int lim, input string tag);
    wait_n(lim * DIV);
    check_pin(1'b1, {tag, " before expiry"});
    wait_n(1);
    check_pin(1'b0, {tag, " expiry"});
  endtask

  task automatic power_up(input logic [1:0] s);
    @(negedge clk);
    por_n = 1'b0;
    sel   = s;
    wait_n(3);
    check_pin(1'b0, "R1 reset state");
    por_n = 1'b1;
    check_release("R1");
  endtask

  task automatic t_power_up;
    power_up(2'b00);
  endtask

  task automatic t_interval(input logic [1:0] s, input int lim, input string tag);
    power_up(s);
    check_expiry(lim, tag);
    check_release("R9 hold after expiry");
  endtask

  task automatic t_kick;
    power_up(2'b01);
    for (int k = 0; k < 4; k++) begin
      wait_n(WS * DIV - 3);
      kick = 1'b1;
      wait_n(1);
      kick = 1'b0;
      check_pin(1'b1, "R7 kick keeps reset off");
    end
    check_expiry(WS, "R7 interval from last kick");
  endtask

  task automatic t_disabled;
    int lows = 0;
    power_up(2'b00);
    for (int i = 0; i < 300; i++) begin
      wait_n(1);
      if (rst_n !== 1'b1) lows++;
    end
    check(lows == 0, "R6 disabled watchdog never fires", lows, 0);
  endtask

  task automatic t_supply;
    power_up(2'b00);
    supply_ok = 1'b0;
    wait_n(1);
    check_pin(1'b0, "R2 supply low asserts");
    wait_n(5);
    check_pin(1'b0, "R2 held while low");
    supply_ok = 1'b1;
    check_release("R3");
  endtask

  task automatic t_restart_hold;
    power_up(2'b00);
    supply_ok = 1'b0;
    wait_n(1);
    supply_ok = 1'b1;
    wait_n(20);
    check_pin(1'b0, "R11 mid hold");
    supply_ok = 1'b0;
    wait_n(1);
    supply_ok = 1'b1;
    check_release("R11");
  endtask

  task automatic t_kick_in_reset;
    power_up(2'b01);
    supply_ok = 1'b0;
    wait_n(1);
    supply_ok = 1'b1;
    for (int i = 1; i < int'(HOLD_CYC); i++) begin
      kick = ((i % 2) == 1) && (i < int'(HOLD_CYC) - 3);
      wait_n(1);
    end
    kick = 1'b0;
    check_pin(1'b0, "R8 kicks ignored, still held");
    wait_n(1);
    check_pin(1'b1, "R8 release unchanged");
    check_expiry(WS, "R8 fresh interval");
  endtask

  initial begin
    por_n     = 1'b0;
    supply_ok = 1'b1;
    kick      = 1'b0;
    sel       = 2'b11;
    t_power_up();
    t_interval(2'b01, WS, "R4 R5 short");
    t_interval(2'b10, WM, "R5 mid");
    t_interval(2'b11, WL, "R5 long");
    t_kick();
    t_disabled();
    t_supply();
    t_restart_hold();
    t_kick_in_reset();
    finished = 1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog timeout", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule